// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block sits between two parallel buses, an A side and a B side, and moves data in both directions at once. Each direction has its own storage path and its own clock. Each side is divided into independent lanes, and each lane carries a data byte and one parity bit. Every lane's storage element can run open (transparent), hold its contents, or capture on a rising clock edge under its own lane enable.

A global control turns parity processing on or off. When it is on, the block produces a fresh parity bit for each outgoing lane from the stored data. It also checks each incoming lane, data and parity together, and raises a per-lane error flag on each side. A sense select applies to generation and checking alike. When parity is off, the block is a plain registered transceiver, and the received parity bits go through the same storage as the data. The output buffers are modelled as a data output plus a per-side drive flag, with no tristate pins.

Top module: `par_xcvr`

## Requirements
- R1: A synchronous active-high reset, taken on the rising edge of each direction's clock, clears every lane's stored data and parity to zero.
- R2: While a direction's latch enable is high, that direction's outputs follow its inputs in the same cycle, and every lane of it loads its input at each rising edge.
- R3: While the latch enable is low, a lane whose clock enable is high loads its input at the rising edge, and the new value appears at the output after that edge.
- R4: While the latch enable is low, a lane whose clock enable is low keeps its stored value, whatever the input does, and other lanes do not affect it.
- R5: The A-to-B and B-to-A paths are independent: each has its own clock, latch enable, per-lane clock enables and output enable.
- R6: With parity disabled (par_en_n high), each lane's output parity bit is its stored received parity bit, and both error vectors are zero.
- R7: With parity enabled (par_en_n low), each lane's output parity bit is generated from the lane's output data. With odd_sel high, the total count of ones in the data and the parity bit is odd. With odd_sel low, that count is even.
- R8: With parity enabled, error bit l of a side is high exactly when that side's incoming lane l (data bits [8l+7:8l] and parity bit l) has a count of ones that does not match the selected sense. This check is combinational on the inputs.
- R9: When a direction's output enable is low, its data and parity outputs are zero and its drive flag is low. When the output enable is high, the drive flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Clock of the A-to-B storage |
| clk_ba | input | 1 | Clock of the B-to-A storage |
| rst | input | 1 | Synchronous active-high reset |
| par_en_n | input | 1 | Parity generate/check enable, active low |
| odd_sel | input | 1 | Parity sense: 1 odd, 0 even |
| ab_le | input | 1 | A-to-B latch enable (high = transparent) |
| ab_ce | input | LANES | A-to-B per-lane clock enable |
| ab_oe | input | 1 | A-to-B output enable |
| ba_le | input | 1 | B-to-A latch enable |
| ba_ce | input | LANES | B-to-A per-lane clock enable |
| ba_oe | input | 1 | B-to-A output enable |
| a_data_i | input | LANES*DW | A-side received data |
| a_par_i | input | LANES | A-side received parity |
| b_data_i | input | LANES*DW | B-side received data |
| b_par_i | input | LANES | B-side received parity |
| b_data_o | output | LANES*DW | Data driven toward B |
| b_par_o | output | LANES | Parity driven toward B |
| b_drive_o | output | 1 | B-side outputs are driven |
| a_data_o | output | LANES*DW | Data driven toward A |
| a_par_o | output | LANES | Parity driven toward A |
| a_drive_o | output | 1 | A-side outputs are driven |
| a_err_o | output | LANES | Per-lane parity error on the A-side inputs |
| b_err_o | output | LANES | Per-lane parity error on the B-side inputs |

## Verification
Transparent outputs, drive flags, generated parity and the error flags are all due in the same cycle as the input change. A captured or held lane value is due only after the next rising edge of its direction's clock. The bench sets inputs after a rising edge and compares at the following falling edge, so every combinational result has settled before the comparison. Its reference copy of the storage is updated only after each rising edge, which shifts an expected capture to the next vector, just as the design does.

// File: rtl/par_xcvr_pkg.sv
package par_xcvr_pkg;

  typedef enum logic {
    SENSE_EVEN = 1'b0,
    SENSE_ODD  = 1'b1
  } sense_e;

  // Parity bit to append to data whose XOR reduction is red.
  function automatic logic make_parity(input logic red, input sense_e s);
    return red ^ logic'(s);
  endfunction

  // Error when the XOR of data plus parity disagrees with the sense.
  function automatic logic parity_bad(input logic red_all, input sense_e s);
    return red_all != logic'(s);
  endfunction

endpackage

// File: rtl/par_lane_store.sv
module par_lane_store #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  // Open latch tracks input at each edge; closed latch loads only under ce.
  always_ff @(posedge clk) begin
    if (rst)
      q_r <= '0;
    else if (le || ce)
      q_r <= d;
  end

  assign q = le ? d : q_r;

endmodule

// File: rtl/par_dir.sv
module par_dir
  import par_xcvr_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                le,
  input  logic [LANES-1:0]    ce,
  input  logic                oe,
  input  logic                par_en_n,
  input  logic                odd_sel,
  input  logic [LANES*DW-1:0] din,
  input  logic [LANES-1:0]    pin,
  output logic [LANES*DW-1:0] dout,
  output logic [LANES-1:0]    pout,
  output logic                drive,
  output logic [LANES-1:0]    err
);

  localparam int SW = DW + 1;

  sense_e sense;
  assign sense = sense_e'(odd_sel);
  assign drive = oe;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SW-1:0] st_q;
    logic [DW-1:0] st_d;
    logic          st_p;
    logic          p_sel;

    par_lane_store #(.W(SW)) u_store (
      .clk (clk),
      .rst (rst),
      .le  (le),
      .ce  (ce[l]),
      .d   ({pin[l], din[l*DW +: DW]}),
      .q   (st_q)
    );

    assign st_d  = st_q[DW-1:0];
    assign st_p  = st_q[DW];
    assign p_sel = par_en_n ? st_p : make_parity(^st_d, sense);

    assign dout[l*DW +: DW] = oe ? st_d : '0;
    assign pout[l]          = oe & p_sel;
    assign err[l]           = !par_en_n &&
                              parity_bad(^{din[l*DW +: DW], pin[l]}, sense);
  end

endmodule

// File: rtl/par_xcvr.sv
module par_xcvr #(
  parameter int LANES = 2,
  parameter int DW    = 8
) (
  input  logic                clk_ab,
  input  logic                clk_ba,
  input  logic                rst,
  input  logic                par_en_n,
  input  logic                odd_sel,
  input  logic                ab_le,
  input  logic [LANES-1:0]    ab_ce,
  input  logic                ab_oe,
  input  logic                ba_le,
  input  logic [LANES-1:0]    ba_ce,
  input  logic                ba_oe,
  input  logic [LANES*DW-1:0] a_data_i,
  input  logic [LANES-1:0]    a_par_i,
  input  logic [LANES*DW-1:0] b_data_i,
  input  logic [LANES-1:0]    b_par_i,
  output logic [LANES*DW-1:0] b_data_o,
  output logic [LANES-1:0]    b_par_o,
  output logic                b_drive_o,
  output logic [LANES*DW-1:0] a_data_o,
  output logic [LANES-1:0]    a_par_o,
  output logic                a_drive_o,
  output logic [LANES-1:0]    a_err_o,
  output logic [LANES-1:0]    b_err_o
);

  par_dir #(.LANES(LANES), .DW(DW)) u_ab (
    .clk      (clk_ab),
    .rst      (rst),
    .le       (ab_le),
    .ce       (ab_ce),
    .oe       (ab_oe),
    .par_en_n (par_en_n),
    .odd_sel  (odd_sel),
    .din      (a_data_i),
    .pin      (a_par_i),
    .dout     (b_data_o),
    .pout     (b_par_o),
    .drive    (b_drive_o),
    .err      (a_err_o)
  );

  par_dir #(.LANES(LANES), .DW(DW)) u_ba (
    .clk      (clk_ba),
    .rst      (rst),
    .le       (ba_le),
    .ce       (ba_ce),
    .oe       (ba_oe),
    .par_en_n (par_en_n),
    .odd_sel  (odd_sel),
    .din      (b_data_i),
    .pin      (b_par_i),
    .dout     (a_data_o),
    .pout     (a_par_o),
    .drive    (a_drive_o),
    .err      (b_err_o)
  );

endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk #(
  parameter int LANES = 2,
  parameter int DW    = 8
) (
  input logic                clk_ab,
  input logic                rst,
  input logic                par_en_n,
  input logic                odd_sel,
  input logic                ab_le,
  input logic [LANES-1:0]    ab_ce,
  input logic                ab_oe,
  input logic [LANES*DW-1:0] a_data_i,
  input logic [LANES*DW-1:0] b_data_o,
  input logic [LANES-1:0]    b_par_o,
  input logic                b_drive_o,
  input logic [LANES-1:0]    a_err_o,
  input logic [LANES-1:0]    b_err_o
);

  AST_IDLE_SIDE: assert property (@(posedge clk_ab) disable iff (rst)
    !ab_oe |-> (b_data_o == '0 && b_par_o == '0 && !b_drive_o)); // R9

  AST_ERR_QUIET: assert property (@(posedge clk_ab) disable iff (rst)
    par_en_n |-> (a_err_o == '0 && b_err_o == '0)); // R6

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_OPEN_FOLLOW: assert property (@(posedge clk_ab) disable iff (rst)
      (ab_le && ab_oe) |-> b_data_o[l*DW +: DW] == a_data_i[l*DW +: DW]); // R2

    AST_EDGE_LOAD: assert property (@(posedge clk_ab) disable iff (rst)
      (!ab_le && ab_oe && $past(!ab_le && ab_ce[l] && !rst))
        |-> b_data_o[l*DW +: DW] == $past(a_data_i[l*DW +: DW])); // R3

    AST_LANE_HOLD: assert property (@(posedge clk_ab) disable iff (rst)
      (!ab_le && ab_oe && $past(ab_oe && !ab_le && !ab_ce[l] && !rst))
        |-> $stable(b_data_o[l*DW +: DW])); // R4

    AST_GEN_SENSE: assert property (@(posedge clk_ab) disable iff (rst)
      (!par_en_n && ab_oe)
        |-> (^{b_data_o[l*DW +: DW], b_par_o[l]}) == odd_sel); // R7
  end

endmodule

bind par_xcvr par_xcvr_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk_ab    (clk_ab),
  .rst       (rst),
  .par_en_n  (par_en_n),
  .odd_sel   (odd_sel),
  .ab_le     (ab_le),
  .ab_ce     (ab_ce),
  .ab_oe     (ab_oe),
  .a_data_i  (a_data_i),
  .b_data_o  (b_data_o),
  .b_par_o   (b_par_o),
  .b_drive_o (b_drive_o),
  .a_err_o   (a_err_o),
  .b_err_o   (b_err_o)
);

// File: tb/par_xcvr_tb.sv
module par_xcvr_tb;

  localparam int LANES = 2;
  localparam int DW    = 8;
  localparam int TW    = LANES * DW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, par_en_n = 1'b1, odd_sel = 1'b0;
  logic ab_le = 1'b0, ab_oe = 1'b1, ba_le = 1'b0, ba_oe = 1'b1;
  logic [LANES-1:0] ab_ce = '0, ba_ce = '0, a_par_i = '0, b_par_i = '0;
  logic [TW-1:0] a_data_i = '0, b_data_i = '0;
  logic [TW-1:0] b_data_o, a_data_o;
  logic [LANES-1:0] b_par_o, a_par_o, a_err_o, b_err_o;
  logic b_drive_o, a_drive_o;

  par_xcvr #(.LANES(LANES), .DW(DW)) u_dut (
    .clk_ab(clk), .clk_ba(clk), .rst(rst), .par_en_n(par_en_n), .odd_sel(odd_sel),
    .ab_le(ab_le), .ab_ce(ab_ce), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_ce(ba_ce), .ba_oe(ba_oe),
    .a_data_i(a_data_i), .a_par_i(a_par_i), .b_data_i(b_data_i), .b_par_i(b_par_i),
    .b_data_o(b_data_o), .b_par_o(b_par_o), .b_drive_o(b_drive_o),
    .a_data_o(a_data_o), .a_par_o(a_par_o), .a_drive_o(a_drive_o),
    .a_err_o(a_err_o), .b_err_o(b_err_o)
  );

  typedef struct {
    string            tag;
    logic [TW-1:0]    bd, ad;
    logic [LANES-1:0] bp, ap, ea, eb;
    logic             bdrv, adrv;
  } exp_t;

  exp_t q[$];
  event ev_push;
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  logic [DW:0] m_ab [LANES];
  logic [DW:0] m_ba [LANES];

  // Reference model of one direction's outputs from its stored state.
  task automatic model_dir(input logic le, input logic oe,
                           input logic [TW-1:0] din, input logic [LANES-1:0] pin,
                           input logic [DW:0] st [LANES],
                           output logic [TW-1:0] dout, output logic [LANES-1:0] pout,
                           output logic [LANES-1:0] err);
    for (int l = 0; l < LANES; l++) begin
      logic [DW:0] s;
      logic        p;
      s = le ? {pin[l], din[l*DW +: DW]} : st[l];
      p = par_en_n ? s[DW] : ((^s[DW-1:0]) ^ odd_sel);
      dout[l*DW +: DW] = oe ? s[DW-1:0] : '0;
      pout[l] = oe & p;
      err[l] = !par_en_n && ((^{din[l*DW +: DW], pin[l]}) != odd_sel);
    end
  endtask

  // Driver: inputs were set after the last rising edge; expected values
  // are formed at the falling edge, then the model storage advances.
  task automatic vec(input string tag, input bit chk = 1'b1);
    exp_t e;
    @(negedge clk);
    e.tag = tag;
    model_dir(ab_le, ab_oe, a_data_i, a_par_i, m_ab, e.bd, e.bp, e.ea);
    model_dir(ba_le, ba_oe, b_data_i, b_par_i, m_ba, e.ad, e.ap, e.eb);
    e.bdrv = ab_oe;
    e.adrv = ba_oe;
    if (chk) begin
      q.push_back(e);
      ->ev_push;
    end
    @(posedge clk);
    for (int l = 0; l < LANES; l++) begin
      if (rst) begin
        m_ab[l] = '0;
        m_ba[l] = '0;
      end else begin
        if (ab_le || ab_ce[l]) m_ab[l] = {a_par_i[l], a_data_i[l*DW +: DW]};
        if (ba_le || ba_ce[l]) m_ba[l] = {b_par_i[l], b_data_i[l*DW +: DW]};
      end
    end
    #1;
  endtask

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(ev_push);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (b_data_o !== e.bd || b_par_o !== e.bp || b_drive_o !== e.bdrv ||
            a_data_o !== e.ad || a_par_o !== e.ap || a_drive_o !== e.adrv ||
            a_err_o !== e.ea || b_err_o !== e.eb) begin
          n_bad++;
          $display("FAIL %s: got b=%h/%b/%b a=%h/%b/%b ea=%b eb=%b exp b=%h/%b/%b a=%h/%b/%b ea=%b eb=%b",
                   e.tag, b_data_o, b_par_o, b_drive_o, a_data_o, a_par_o, a_drive_o,
                   a_err_o, b_err_o, e.bd, e.bp, e.bdrv, e.ad, e.ap, e.adrv, e.ea, e.eb);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin
      m_ab[l] = '0;
      m_ba[l] = '0;
    end
    a_data_i = 16'hffff; a_par_i = 2'b11; b_data_i = 16'hffff; b_par_i = 2'b11;
    vec("R1 reset edge", 1'b0);
    vec("R1 reset edge", 1'b0);
    rst = 1'b0;
    vec("R1 cleared after reset");

    // R2 transparent A-to-B
    ab_le = 1'b1; a_data_i = 16'h5aa5; a_par_i = 2'b10;
    vec("R2 open follow");
    a_data_i = 16'h1234; a_par_i = 2'b01;
    vec("R2 open follow new value");
    // R4 close latch: holds the value loaded at the last open edge
    ab_le = 1'b0; ab_ce = 2'b00; a_data_i = 16'hffff; a_par_i = 2'b11;
    vec("R4 hold after close");
    vec("R4 hold second cycle");
    // R3 lane 0 capture only
    ab_ce = 2'b01; a_data_i = 16'habcd; a_par_i = 2'b10;
    vec("R3 before edge");
    ab_ce = 2'b00;
    vec("R3 lane0 captured, R4 lane1 held");
    ab_ce = 2'b10; a_data_i = 16'h0000; a_par_i = 2'b00;
    vec("R3 lane1 before edge");
    ab_ce = 2'b00; a_data_i = 16'h7777;
    vec("R3 lane1 captured, R4 lane0 held");

    // R5 B-to-A independent of A-to-B
    ba_le = 1'b1; b_data_i = 16'hbeef; b_par_i = 2'b01;
    vec("R5 B-to-A open while A-to-B holds");
    ba_le = 1'b0; ba_ce = 2'b11; b_data_i = 16'h1111;
    vec("R5 B-to-A before capture");
    ba_ce = 2'b00; b_data_i = 16'h2222;
    vec("R5 B-to-A captured");

    // R9 output enables
    ab_oe = 1'b0;
    vec("R9 A-to-B not driven");
    ba_oe = 1'b0; ab_oe = 1'b1;
    vec("R9 B-to-A not driven");
    ba_oe = 1'b1;

    // R6 pass-through parity, bad parity raises no error
    ab_le = 1'b1; a_data_i = 16'h0100; a_par_i = 2'b01;
    vec("R6 parity passes, errors low");

    // R7 generation, both senses
    par_en_n = 1'b0; odd_sel = 1'b0; a_data_i = 16'h0103; a_par_i = 2'b00;
    vec("R7 even sense generate");
    odd_sel = 1'b1;
    vec("R7 odd sense generate");

    // R8 checking on both sides
    odd_sel = 1'b0; a_data_i = 16'h0300; a_par_i = 2'b01; b_data_i = 16'h0001; b_par_i = 2'b11;
    vec("R8 even sense mixed errors");
    odd_sel = 1'b1;
    vec("R8 odd sense mixed errors");

    // R1 mid-run reset
    rst = 1'b1; ab_le = 1'b0; ba_le = 1'b0;
    vec("R1 reset asserted", 1'b0);
    rst = 1'b0; par_en_n = 1'b1;
    vec("R1 storage cleared mid-run");

    // Mixed sweep over all controls, R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 300; i++) begin
      par_en_n = 1'($urandom); odd_sel = 1'($urandom);
      ab_le = (($urandom % 4) == 0); ba_le = (($urandom % 4) == 0);
      ab_ce = LANES'($urandom); ba_ce = LANES'($urandom);
      ab_oe = (($urandom % 5) != 0); ba_oe = (($urandom % 5) != 0);
      a_data_i = TW'($urandom); b_data_i = TW'($urandom);
      a_par_i = LANES'($urandom); b_par_i = LANES'($urandom);
      vec("R2-sweep mixed controls");
    end

    #10;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule